// File: doc/BRIEF.md
# Non-retriggerable dual-input one-shot

This block is a clocked monostable pulse generator. It has two trigger inputs of opposite sense: `trig_fall` fires on a falling edge and `trig_rise` fires on a rising edge. Each trigger is gated by the level of the other input, so either input can serve as an inhibit for the other. When the block fires, the output `q` goes high for a number of clock cycles. That number is taken from the `len` input at the moment of firing. `q_n` is always the complement of `q`.

Once a pulse has started, the block ignores its trigger inputs until the pulse ends. The active-low `clr_n` input overrides everything else: it ends a pulse at once and blocks all triggering. The release of `clr_n` can itself start a pulse, but only if an internal arming latch was set beforehand. The latch is set whenever `trig_fall` is high or `trig_rise` is low while clear is inactive. Firing clears it.

All inputs are assumed to be synchronous to `clk` already. Reset is synchronous and active high.

Top module: `oneshot_dual_trig`

## Requirements
- R1: With `clr_n` high and `trig_rise` high, a falling edge on `trig_fall` starts a pulse. `q` rises after the clock edge that samples the falling edge.
- R2: With `clr_n` high and `trig_fall` low, a rising edge on `trig_rise` starts a pulse.
- R3: While `trig_fall` is high or `trig_rise` is low, no pulse starts. In that state `q` stays 0 and `q_n` stays 1.
- R4: While a pulse is running, edges on `trig_fall` and `trig_rise` neither extend nor restart it. An edge seen during the last high cycle of a pulse is also ignored.
- R5: `q` stays high for exactly `len` cycles, using the value of `len` sampled at the firing edge. A `len` of 0 gives 1 cycle. Changing `len` during a pulse has no effect.
- R6: `clr_n` low forces `q` to 0 in the same cycle, without waiting for a clock edge, and ends any running pulse.
- R7: A rising edge on `clr_n`, sampled while `trig_fall` is low and `trig_rise` is high, starts a pulse only if the arming latch is set. The latch is set by `trig_fall` high or `trig_rise` low while `clr_n` is high, and it is cleared by any firing.
- R8: A trigger edge that occurs while `clr_n` is low is not remembered. It does not start a pulse after `clr_n` is released.
- R9: `q_n` equals the complement of `q` at all times after reset.
- R10: During reset, and in the first cycle after it, `q` is 0. Reset also clears the edge history, the pulse counter and the arming latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Overriding clear, active low |
| trig_fall | input | 1 | Trigger input that fires on a falling edge |
| trig_rise | input | 1 | Trigger input that fires on a rising edge |
| len | input | WIDTH | Pulse length in cycles, sampled when the block fires |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench aims at several corner cases:
- A release of clear with and without the arming latch set. A design that ignored the latch would fire on every release, or on none.
- Trigger edges made while clear is low. A design that froze its edge history during clear would fire late, on the release.
- Edges on the final high cycle of a pulse, and a `len` of 0. A wrong design would give a doubled pulse or a pulse of zero length.
- An assertion of clear in the middle of a pulse. This exposes a registered rather than immediate clear.

Random stimulus with biased toggling then compares every cycle against a reference model held in the bench.

// File: rtl/oneshot_dual_trig.sv
module oneshot_dual_trig #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             trig_fall,
  input  logic             trig_rise,
  input  logic [WIDTH-1:0] len,
  output logic             q,
  output logic             q_n
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             fall_q, rise_q, clr_q, arm;
  logic [WIDTH-1:0] cnt;
  logic             busy, gate_ok, fire, arm_set;
  logic [WIDTH-1:0] load;

  assign busy    = (cnt != '0);
  assign gate_ok = clr_n & ~trig_fall & trig_rise;
  assign fire    = ~busy & gate_ok & (fall_q | ~rise_q | (~clr_q & arm));
  assign arm_set = clr_n & (trig_fall | ~trig_rise);
  assign load    = (len == '0) ? ONE : len;

  assign q   = busy & clr_n;
  assign q_n = ~q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
      rise_q <= 1'b1;
      clr_q  <= 1'b1;
      arm    <= 1'b0;
      cnt    <= '0;
    end else begin
      fall_q <= trig_fall;
      rise_q <= trig_rise;
      clr_q  <= clr_n;
      if (arm_set)   arm <= 1'b1;
      else if (fire) arm <= 1'b0;
      if (!clr_n)    cnt <= '0;
      else if (fire) cnt <= load;
      else if (busy) cnt <= cnt - ONE;
    end
  end

  assert_clear_forces_low_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> !q);

  assert_complement_R9: assert property (@(posedge clk) disable iff (rst)
    q_n == !q);

  assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && clr_n) |=> (cnt == $past(cnt) - ONE));

  assert_length_loaded_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt == (($past(len) == '0) ? ONE : $past(len))));

  assert_fires_only_when_gated_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(clr_n) && !$past(trig_fall) && $past(trig_rise)));
endmodule

// File: tb/tb_oneshot_dual_trig.sv
module tb_oneshot_dual_trig;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst, clr_n, trig_fall, trig_rise;
  logic [W-1:0] len;
  logic         q, q_n;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R10";
  int    hi_cnt;

  bit m_pa, m_pb, m_pc, m_arm;
  int m_cnt;

  oneshot_dual_trig #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .trig_fall(trig_fall),
    .trig_rise(trig_rise), .len(len), .q(q), .q_n(q_n)
  );

  always #10 clk = ~clk;

  function automatic bit exp_q(bit c);
    return (m_cnt != 0) && c;
  endfunction

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_step(bit r, bit a, bit b, bit c, int l);
    bit busy, f;
    if (r) begin
      m_pa = 0; m_pb = 1; m_pc = 1; m_arm = 0; m_cnt = 0;
      return;
    end
    busy = (m_cnt != 0);
    f = !busy && c && !a && b && (m_pa || !m_pb || (!m_pc && m_arm));
    if (!c) m_cnt = 0;
    else if (f) m_cnt = (l == 0) ? 1 : l;
    else if (busy) m_cnt--;
    if (c && (a || !b)) m_arm = 1;
    else if (f) m_arm = 0;
    m_pa = a; m_pb = b; m_pc = c;
  endtask

  task automatic cyc(bit a, bit b, bit c, int l);
    @(negedge clk);
    trig_fall = a; trig_rise = b; clr_n = c; len = l[W-1:0];
    #1;
    chk(cur_req, q, exp_q(c));
    chk("R9", q_n, !q);
    if (q) hi_cnt++;
    model_step(0, a, b, c, l);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; trig_fall = 0; trig_rise = 1; clr_n = 1; len = 3;
    model_step(1, 0, 1, 1, 3);
    @(negedge clk);
    #1;
    chk("R10", q, 0);
    chk("R10", q_n, 1);
    rst = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    rst = 1; trig_fall = 0; trig_rise = 1; clr_n = 1; len = 0;
    do_reset();
    cur_req = "R10";
    cyc(0, 1, 1, 3);
    chk("R10", q, 0);

    cur_req = "R1"; hi_cnt = 0;
    cyc(1, 1, 1, 5);
    cyc(0, 1, 1, 5);
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, 9);
    chk("R5", hi_cnt, 5);

    cur_req = "R2"; hi_cnt = 0;
    cyc(0, 0, 1, 3);
    cyc(0, 1, 1, 3);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 3);
    chk("R2", hi_cnt, 3);

    cur_req = "R3"; hi_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 1, 4); cyc(1, 1, 1, 4); cyc(1, 0, 1, 4);
    end
    cyc(1, 0, 1, 4); cyc(0, 0, 1, 4); cyc(0, 0, 1, 4);
    chk("R3", hi_cnt, 0);

    cur_req = "R4"; hi_cnt = 0;
    cyc(0, 0, 1, 4);
    cyc(0, 1, 1, 4);
    cyc(1, 1, 1, 4); cyc(0, 1, 1, 4); cyc(0, 0, 1, 4); cyc(0, 1, 1, 4);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 4);
    chk("R4", hi_cnt, 4);

    cur_req = "R5"; hi_cnt = 0;
    cyc(1, 1, 1, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    chk("R5", hi_cnt, 1);
    hi_cnt = 0;
    cyc(1, 1, 1, 2); cyc(0, 1, 1, 2);
    cyc(0, 1, 1, 15); cyc(0, 1, 1, 15); cyc(0, 1, 1, 15); cyc(0, 1, 1, 15);
    chk("R5", hi_cnt, 2);

    cur_req = "R6"; hi_cnt = 0;
    cyc(1, 1, 1, 10); cyc(0, 1, 1, 10);
    cyc(0, 1, 1, 10); cyc(0, 1, 1, 10);
    cyc(0, 1, 0, 10);
    chk("R6", q, 0);
    cyc(0, 1, 0, 10);
    cyc(1, 1, 1, 10);
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 10);
    chk("R6", hi_cnt, 2);

    cur_req = "R7"; hi_cnt = 0;
    cyc(1, 1, 1, 3);
    cyc(0, 1, 0, 3); cyc(0, 1, 0, 3);
    cyc(0, 1, 1, 3);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 3);
    chk("R7", hi_cnt, 3);
    hi_cnt = 0;
    cyc(0, 1, 0, 3); cyc(0, 1, 0, 3);
    cyc(0, 1, 1, 3);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 3);
    chk("R7", hi_cnt, 0);

    cur_req = "R8"; hi_cnt = 0;
    cyc(0, 1, 0, 3);
    cyc(1, 0, 0, 3); cyc(0, 1, 0, 3);
    cyc(0, 1, 1, 3);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 3);
    chk("R8", hi_cnt, 0);

    cur_req = "R1";
    for (int i = 0; i < 4000; i++) begin
      bit a = trig_fall, b = trig_rise, c = clr_n;
      if ($urandom_range(0, 5) == 0) a = ~a;
      if ($urandom_range(0, 5) == 0) b = ~b;
      if ($urandom_range(0, 19) == 0) c = ~c;
      cur_req = (i % 2 == 0) ? "R2" : "R7";
      cyc(a, b, c, int'($urandom_range(0, 15)));
      if ($urandom_range(0, 999) == 0) begin
        do_reset();
        cur_req = "R10";
        cyc(0, 1, 1, 3);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule